// File: doc/BRIEF.md
# In-group store-load overlap detector

This block keeps a small record of the stores placed into the instruction group that is being formed. For any candidate load, it reports in the same cycle whether that load could read bytes that one of those stores writes. A scheduler uses the result to keep such a load out of the group, because a load that collides with an earlier store in the same group is costly to recover from. Each recorded store, and the load query, describe their address with two operands: a first operand that is either a register tag or a constant offset, and a base register tag. Each also carries an access-size code. Decoding opcodes into access sizes happens elsewhere; the size arrives here as a 2-bit code.

A store-accept strobe appends one entry to the table. A group-end strobe empties the table. The table depth is a parameter (four by default). A push into a full table is dropped and sets a flag that stays set until the group ends. The overlap output is purely combinational from the registered table and the load inputs. A store accepted in a cycle is therefore seen by loads from the next cycle onward.

Top module: `sov_overlap_det`

## Requirements
- R1: A load hits a valid entry when its first operands are equal and its base tags are equal. First operands are equal when both are registers with the same tag, or both are constants with the same 16-bit value. The tag of a constant operand is ignored.
- R2: A load hits a valid entry when both first operands are registers, the load's first tag equals the entry's base tag, and the load's base tag equals the entry's first tag (operand-swapped address).
- R3: When base tags are equal, both first operands are constants, and the store offset is below the load offset, the load hits exactly when store offset plus store size is greater than the load offset. The sum is formed at 17 bits, so it never wraps.
- R4: Under the same conditions, but with the store offset at or above the load offset, the load hits exactly when load offset plus load size is greater than the store offset.
- R5: The size code maps 0 to 1 byte, 1 to 2 bytes, 2 to 4 bytes and 3 to 8 bytes. This holds for both store and load sizes.
- R6: With no stores recorded, `hit_o` is 0 whatever the load inputs are.
- R7: A push with room in the table and no group end stores the entry and raises `st_count_o` by one at the next clock. The count never exceeds DEPTH.
- R8: A push when `st_count_o` equals DEPTH leaves the table and count unchanged and sets `overflow_o` from the next clock. `overflow_o` then stays set until a group end or reset.
- R9: A group end clears all entries, the count and `overflow_o` at the next clock. A push in the same cycle becomes the first entry of the new group, so the count becomes 1.
- R10: After reset the count is 0, `overflow_o` is 0 and `hit_o` is 0.
- R11: No hit arises from an entry whose base tag differs from the load's, unless the swapped match applies. No hit arises when exactly one of the two first operands is a constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_end_i | input | 1 | Group-end strobe; empties the table |
| st_push_i | input | 1 | Store-accept strobe; appends one entry |
| st_opa_tag_i | input | TAG_W | Store first-operand register tag |
| st_base_tag_i | input | TAG_W | Store base register tag |
| st_opa_const_i | input | 1 | Store first operand is a constant |
| st_ofs_i | input | OFS_W | Store constant offset |
| st_size_i | input | 2 | Store size code (R5) |
| ld_opa_tag_i | input | TAG_W | Load first-operand register tag |
| ld_base_tag_i | input | TAG_W | Load base register tag |
| ld_opa_const_i | input | 1 | Load first operand is a constant |
| ld_ofs_i | input | OFS_W | Load constant offset |
| ld_size_i | input | 2 | Load size code (R5) |
| hit_o | output | 1 | Load overlaps a recorded store (combinational) |
| st_count_o | output | CNT_W | Number of recorded stores |
| overflow_o | output | 1 | Sticky: a push was dropped because the table was full |

## Verification
Directed loads are placed one byte either side of each interval edge for every size code. This separates strict from non-strict comparisons and shows which size code each comparison uses. An offset near the top of the 16-bit range exposes an interval sum that wraps. The directed cases also pair a register first operand with a constant one, and use mismatched bases, so that the exact, swapped and interval paths can be told apart. Random traffic over a small tag and offset space then mixes pushes, group ends, overflowing pushes and loads. Every load is checked against an independent byte-range model, and the count and overflow flag are checked after every clock.

// File: rtl/sov_pkg.sv
package sov_pkg;

    // Access-size codes
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } sov_size_e;

    // Byte count of an access-size code: 1, 2, 4 or 8
    function automatic logic [3:0] sov_size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/sov_interval.sv
// Interval test between two constant-offset accesses on the same base
module sov_interval #(
    parameter int OFS_W = 16
) (
    input  logic [OFS_W-1:0] st_ofs,
    input  logic [1:0]       st_sz,
    input  logic [OFS_W-1:0] ld_ofs,
    input  logic [1:0]       ld_sz,
    output logic             ovl
);
    import sov_pkg::*;

    localparam int SUM_W = OFS_W + 1;

    logic [SUM_W-1:0] st_ext;
    logic [SUM_W-1:0] ld_ext;
    logic [SUM_W-1:0] st_end;
    logic [SUM_W-1:0] ld_end;

    always_comb begin
        st_ext = {1'b0, st_ofs};
        ld_ext = {1'b0, ld_ofs};
        st_end = st_ext + SUM_W'(sov_size_bytes(st_sz));
        ld_end = ld_ext + SUM_W'(sov_size_bytes(ld_sz));
        if (st_ofs < ld_ofs) begin
            ovl = (st_end > ld_ext);
        end else begin
            ovl = (ld_end > st_ext);
        end
    end

endmodule

// File: rtl/sov_entry_match.sv
// Compares one recorded store against the load query
module sov_entry_match #(
    parameter int TAG_W = 4,
    parameter int OFS_W = 16
) (
    input  logic             ent_vld,
    input  logic [TAG_W-1:0] st_opa_tag,
    input  logic [TAG_W-1:0] st_base_tag,
    input  logic             st_opa_const,
    input  logic [OFS_W-1:0] st_ofs,
    input  logic [1:0]       st_sz,
    input  logic [TAG_W-1:0] ld_opa_tag,
    input  logic [TAG_W-1:0] ld_base_tag,
    input  logic             ld_opa_const,
    input  logic [OFS_W-1:0] ld_ofs,
    input  logic [1:0]       ld_sz,
    output logic             hit
);

    logic base_eq;
    logic opa_eq;
    logic both_reg;
    logic both_const;
    logic exact_m;
    logic swap_m;
    logic span_ovl;
    logic span_m;

    sov_interval #(
        .OFS_W(OFS_W)
    ) u_span (
        .st_ofs (st_ofs),
        .st_sz  (st_sz),
        .ld_ofs (ld_ofs),
        .ld_sz  (ld_sz),
        .ovl    (span_ovl)
    );

    always_comb begin
        base_eq    = (st_base_tag == ld_base_tag);
        both_reg   = !st_opa_const && !ld_opa_const;
        both_const = st_opa_const && ld_opa_const;
        // first operand equality: same kind, then same tag or same value
        opa_eq     = (both_reg && (st_opa_tag == ld_opa_tag)) ||
                     (both_const && (st_ofs == ld_ofs));
        exact_m    = opa_eq && base_eq;
        swap_m     = both_reg &&
                     (ld_opa_tag == st_base_tag) &&
                     (ld_base_tag == st_opa_tag);
        span_m     = base_eq && both_const && span_ovl;
        hit        = ent_vld && (exact_m || swap_m || span_m);
    end

endmodule

// File: rtl/sov_table.sv
// Store record: append on push, flush on group end
module sov_table #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 4,
    parameter int OFS_W = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         grp_end,
    input  logic                         push,
    input  logic [TAG_W-1:0]             in_opa_tag,
    input  logic [TAG_W-1:0]             in_base_tag,
    input  logic                         in_opa_const,
    input  logic [OFS_W-1:0]             in_ofs,
    input  logic [1:0]                   in_sz,
    output logic [DEPTH-1:0]             vld,
    output logic [DEPTH-1:0][TAG_W-1:0]  opa_tag,
    output logic [DEPTH-1:0][TAG_W-1:0]  base_tag,
    output logic [DEPTH-1:0]             opa_const,
    output logic [DEPTH-1:0][OFS_W-1:0]  ofs,
    output logic [DEPTH-1:0][1:0]        sz,
    output logic [CNT_W-1:0]             cnt,
    output logic                         ovf
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0][TAG_W-1:0] opa_tag;
        logic [DEPTH-1:0][TAG_W-1:0] base_tag;
        logic [DEPTH-1:0]            opa_const;
        logic [DEPTH-1:0][OFS_W-1:0] ofs;
        logic [DEPTH-1:0][1:0]       sz;
        logic [CNT_W-1:0]            cnt;
        logic                        ovf;
    } tbl_t;

    tbl_t tbl_d;
    tbl_t tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (grp_end) begin
            tbl_d.vld = '0;
            tbl_d.cnt = '0;
            tbl_d.ovf = 1'b0;
        end
        if (push) begin
            if (tbl_d.cnt < FULL) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (tbl_d.cnt == CNT_W'(i)) begin
                        tbl_d.vld[i]       = 1'b1;
                        tbl_d.opa_tag[i]   = in_opa_tag;
                        tbl_d.base_tag[i]  = in_base_tag;
                        tbl_d.opa_const[i] = in_opa_const;
                        tbl_d.ofs[i]       = in_ofs;
                        tbl_d.sz[i]        = in_sz;
                    end
                end
                tbl_d.cnt = tbl_d.cnt + CNT_W'(1);
            end else begin
                tbl_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign vld       = tbl_q.vld;
    assign opa_tag   = tbl_q.opa_tag;
    assign base_tag  = tbl_q.base_tag;
    assign opa_const = tbl_q.opa_const;
    assign ofs       = tbl_q.ofs;
    assign sz        = tbl_q.sz;
    assign cnt       = tbl_q.cnt;
    assign ovf       = tbl_q.ovf;

endmodule

// File: rtl/sov_overlap_det.sv
// Top: store record plus one comparator per entry
module sov_overlap_det #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 4,
    parameter int OFS_W = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_end_i,
    input  logic             st_push_i,
    input  logic [TAG_W-1:0] st_opa_tag_i,
    input  logic [TAG_W-1:0] st_base_tag_i,
    input  logic             st_opa_const_i,
    input  logic [OFS_W-1:0] st_ofs_i,
    input  logic [1:0]       st_size_i,
    input  logic [TAG_W-1:0] ld_opa_tag_i,
    input  logic [TAG_W-1:0] ld_base_tag_i,
    input  logic             ld_opa_const_i,
    input  logic [OFS_W-1:0] ld_ofs_i,
    input  logic [1:0]       ld_size_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] st_count_o,
    output logic             overflow_o
);

    logic [DEPTH-1:0]            e_vld;
    logic [DEPTH-1:0][TAG_W-1:0] e_opa_tag;
    logic [DEPTH-1:0][TAG_W-1:0] e_base_tag;
    logic [DEPTH-1:0]            e_opa_const;
    logic [DEPTH-1:0][OFS_W-1:0] e_ofs;
    logic [DEPTH-1:0][1:0]       e_sz;
    logic [DEPTH-1:0]            e_hit;

    sov_table #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W),
        .OFS_W (OFS_W),
        .CNT_W (CNT_W)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .grp_end      (grp_end_i),
        .push         (st_push_i),
        .in_opa_tag   (st_opa_tag_i),
        .in_base_tag  (st_base_tag_i),
        .in_opa_const (st_opa_const_i),
        .in_ofs       (st_ofs_i),
        .in_sz        (st_size_i),
        .vld          (e_vld),
        .opa_tag      (e_opa_tag),
        .base_tag     (e_base_tag),
        .opa_const    (e_opa_const),
        .ofs          (e_ofs),
        .sz           (e_sz),
        .cnt          (st_count_o),
        .ovf          (overflow_o)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        sov_entry_match #(
            .TAG_W (TAG_W),
            .OFS_W (OFS_W)
        ) u_match (
            .ent_vld      (e_vld[g]),
            .st_opa_tag   (e_opa_tag[g]),
            .st_base_tag  (e_base_tag[g]),
            .st_opa_const (e_opa_const[g]),
            .st_ofs       (e_ofs[g]),
            .st_sz        (e_sz[g]),
            .ld_opa_tag   (ld_opa_tag_i),
            .ld_base_tag  (ld_base_tag_i),
            .ld_opa_const (ld_opa_const_i),
            .ld_ofs       (ld_ofs_i),
            .ld_sz        (ld_size_i),
            .hit          (e_hit[g])
        );
    end

    assign hit_o = |e_hit;

endmodule

// File: rtl/sov_overlap_chk.sv
module sov_overlap_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             grp_end_i,
    input logic             st_push_i,
    input logic             hit_o,
    input logic [CNT_W-1:0] st_count_o,
    input logic             overflow_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    p_empty_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_count_o == '0) |-> !hit_o);

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_push_i && !grp_end_i && st_count_o < FULL)
        |=> st_count_o == $past(st_count_o) + CNT_W'(1));

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_count_o <= FULL);

    p_full_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_push_i && !grp_end_i && st_count_o == FULL)
        |=> (st_count_o == FULL && overflow_o));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !grp_end_i) |=> overflow_o);

    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> ($past(st_push_i) && $past(st_count_o) == FULL));

    p_grp_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end_i |=> (!overflow_o &&
                       st_count_o == ($past(st_push_i) ? CNT_W'(1) : CNT_W'(0))));

endmodule

bind sov_overlap_det sov_overlap_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp_end_i  (grp_end_i),
    .st_push_i  (st_push_i),
    .hit_o      (hit_o),
    .st_count_o (st_count_o),
    .overflow_o (overflow_o)
);

// File: tb/sov_overlap_det_tb.sv
module sov_overlap_det_tb;

    localparam int DEPTH = 4;
    localparam int TAG_W = 4;
    localparam int OFS_W = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             grp_end_i = 1'b0;
    logic             st_push_i = 1'b0;
    logic [TAG_W-1:0] st_opa_tag_i = '0;
    logic [TAG_W-1:0] st_base_tag_i = '0;
    logic             st_opa_const_i = 1'b0;
    logic [OFS_W-1:0] st_ofs_i = '0;
    logic [1:0]       st_size_i = '0;
    logic [TAG_W-1:0] ld_opa_tag_i = '0;
    logic [TAG_W-1:0] ld_base_tag_i = '0;
    logic             ld_opa_const_i = 1'b0;
    logic [OFS_W-1:0] ld_ofs_i = '0;
    logic [1:0]       ld_size_i = '0;
    logic             hit_o;
    logic [CNT_W-1:0] st_count_o;
    logic             overflow_o;

    always #10 clk = ~clk;

    sov_overlap_det #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W),
        .OFS_W (OFS_W)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .grp_end_i      (grp_end_i),
        .st_push_i      (st_push_i),
        .st_opa_tag_i   (st_opa_tag_i),
        .st_base_tag_i  (st_base_tag_i),
        .st_opa_const_i (st_opa_const_i),
        .st_ofs_i       (st_ofs_i),
        .st_size_i      (st_size_i),
        .ld_opa_tag_i   (ld_opa_tag_i),
        .ld_base_tag_i  (ld_base_tag_i),
        .ld_opa_const_i (ld_opa_const_i),
        .ld_ofs_i       (ld_ofs_i),
        .ld_size_i      (ld_size_i),
        .hit_o          (hit_o),
        .st_count_o     (st_count_o),
        .overflow_o     (overflow_o)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference table
    int m_cnt = 0;
    bit m_ovf = 1'b0;
    int m_ta [DEPTH];
    int m_tb [DEPTH];
    bit m_ac [DEPTH];
    int m_ofs [DEPTH];
    int m_sz [DEPTH];

    // stimulus held until the next step
    bit g_end, g_push;
    int s_ta, s_tb, s_ofs, s_sz;
    bit s_ac;
    int l_ta, l_tb, l_ofs, l_sz;
    bit l_ac;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int nbytes(input int code);
        return 1 << code;
    endfunction

    // expected hit and the rule it comes from
    function automatic bit ref_hit(output string why);
        bit h = 1'b0;
        why = (m_cnt == 0) ? "R6" : "R11";
        for (int i = 0; i < m_cnt; i++) begin
            bit ex, sw, iv;
            ex = (m_tb[i] == l_tb) && (m_ac[i] == l_ac) &&
                 (l_ac ? (m_ofs[i] == l_ofs) : (m_ta[i] == l_ta));
            sw = !m_ac[i] && !l_ac && (l_ta == m_tb[i]) && (l_tb == m_ta[i]);
            iv = (m_tb[i] == l_tb) && m_ac[i] && l_ac &&
                 (m_ofs[i] < l_ofs + nbytes(l_sz)) &&
                 (l_ofs < m_ofs[i] + nbytes(m_sz[i]));
            if (!h) begin
                if (ex) why = "R1";
                else if (sw) why = "R2";
                else if (iv) why = (m_ofs[i] < l_ofs) ? "R3" : "R4";
            end
            h = h | ex | sw | iv;
        end
        return h;
    endfunction

    task automatic step();
        bit exp_h;
        string why;
        @(negedge clk);
        grp_end_i      = g_end;
        st_push_i      = g_push;
        st_opa_tag_i   = TAG_W'(s_ta);
        st_base_tag_i  = TAG_W'(s_tb);
        st_opa_const_i = s_ac;
        st_ofs_i       = OFS_W'(s_ofs);
        st_size_i      = 2'(s_sz);
        ld_opa_tag_i   = TAG_W'(l_ta);
        ld_base_tag_i  = TAG_W'(l_tb);
        ld_opa_const_i = l_ac;
        ld_ofs_i       = OFS_W'(l_ofs);
        ld_size_i      = 2'(l_sz);
        #1;
        exp_h = ref_hit(why);
        chk(hit_o == exp_h, why, "hit_o", int'(hit_o), int'(exp_h));
        @(posedge clk);
        #1;
        if (g_end) begin
            m_cnt = 0;
            m_ovf = 1'b0;
        end
        if (g_push) begin
            if (m_cnt < DEPTH) begin
                m_ta[m_cnt] = s_ta; m_tb[m_cnt] = s_tb; m_ac[m_cnt] = s_ac;
                m_ofs[m_cnt] = s_ofs; m_sz[m_cnt] = s_sz;
                m_cnt++;
            end else begin
                m_ovf = 1'b1;
            end
        end
        chk(int'(st_count_o) == m_cnt, g_end ? "R9" : "R7", "st_count_o",
            int'(st_count_o), m_cnt);
        chk(overflow_o == m_ovf, g_end ? "R9" : "R8", "overflow_o",
            int'(overflow_o), int'(m_ovf));
    endtask

    task automatic set_st(input bit push, input int ta, input int tb, input bit ac,
                          input int ofs, input int sz);
        g_push = push; s_ta = ta; s_tb = tb; s_ac = ac; s_ofs = ofs; s_sz = sz;
    endtask

    task automatic set_ld(input int ta, input int tb, input bit ac,
                          input int ofs, input int sz);
        l_ta = ta; l_tb = tb; l_ac = ac; l_ofs = ofs; l_sz = sz;
    endtask

    task automatic flush();
        g_end = 1'b1; set_st(1'b0, 0, 0, 1'b0, 0, 0); step(); g_end = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        g_end = 1'b0;
        set_st(1'b0, 0, 0, 1'b0, 0, 0);
        set_ld(0, 0, 1'b0, 0, 0);
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk(st_count_o == '0, "R10", "st_count_o", int'(st_count_o), 0);
        chk(overflow_o == 1'b0, "R10", "overflow_o", int'(overflow_o), 0);
        chk(hit_o == 1'b0, "R10", "hit_o", int'(hit_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 empty table: a load equal to nothing recorded
        set_ld(2, 3, 1'b0, 0, 3); step();

        // R1 exact, R2 swapped, R11 kind mismatch
        set_st(1'b1, 2, 3, 1'b0, 0, 2); step();
        set_st(1'b0, 0, 0, 1'b0, 0, 0);
        set_ld(2, 3, 1'b0, 0, 0); step();   // R1
        set_ld(3, 2, 1'b0, 0, 0); step();   // R2
        set_ld(2, 3, 1'b1, 0, 0); step();   // R11
        set_ld(2, 1, 1'b0, 0, 0); step();   // R11
        flush();

        // R3/R4 edges: store [8,12) on base 5
        set_st(1'b1, 9, 5, 1'b1, 8, 2); step();
        set_st(1'b0, 0, 0, 1'b0, 0, 0);
        set_ld(0, 5, 1'b1, 12, 0); step();  // R3 miss
        set_ld(0, 5, 1'b1, 11, 0); step();  // R3 hit
        set_ld(0, 5, 1'b1, 4, 2);  step();  // R4 miss
        set_ld(0, 5, 1'b1, 5, 2);  step();  // R4 hit
        set_ld(0, 5, 1'b1, 8, 0);  step();  // equal offsets
        set_ld(0, 6, 1'b1, 9, 0);  step();  // R11 other base
        flush();

        // R3 no wrap at the top of the offset range
        set_st(1'b1, 0, 1, 1'b1, 16'hFFF8, 3); step();
        set_st(1'b0, 0, 0, 1'b0, 0, 0);
        set_ld(0, 1, 1'b1, 16'hFFFF, 0); step();
        set_ld(0, 1, 1'b1, 0, 0); step();
        flush();

        // R5 each size code: last byte hits, next byte misses
        for (int k = 0; k < 4; k++) begin
            set_st(1'b1, 0, 7, 1'b1, 32, k); step();
            set_st(1'b0, 0, 0, 1'b0, 0, 0);
            set_ld(0, 7, 1'b1, 32 + nbytes(k) - 1, 0); step();
            chk(hit_o == 1'b1, "R5", "last byte of store", int'(hit_o), 1);
            set_ld(0, 7, 1'b1, 32 + nbytes(k), 0); step();
            chk(hit_o == 1'b0, "R5", "byte past store", int'(hit_o), 0);
            set_ld(0, 7, 1'b1, 32 - nbytes(k), k); step();
            chk(hit_o == 1'b0, "R5", "load ending at store", int'(hit_o), 0);
            flush();
        end

        // R8 overflow, R9 flush with simultaneous push
        for (int i = 0; i < DEPTH + 2; i++) begin
            set_st(1'b1, i, 8, 1'b0, 0, 0); step();
        end
        set_st(1'b0, 0, 0, 1'b0, 0, 0);
        set_ld(DEPTH + 1, 8, 1'b0, 0, 0); step();  // dropped entry, no hit
        chk(overflow_o == 1'b1, "R8", "overflow sticky", int'(overflow_o), 1);
        g_end = 1'b1; set_st(1'b1, 4, 4, 1'b0, 0, 0); step(); g_end = 1'b0;
        set_st(1'b0, 0, 0, 1'b0, 0, 0);
        chk(int'(st_count_o) == 1, "R9", "count after flush+push", int'(st_count_o), 1);
        set_ld(4, 4, 1'b0, 0, 0); step();

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            g_end = ($urandom_range(0, 99) < 12);
            set_st($urandom_range(0, 99) < 40, $urandom_range(0, 3), $urandom_range(0, 3),
                   1'($urandom_range(0, 1)),
                   ($urandom_range(0, 9) == 0) ? $urandom_range(16'hFFF0, 16'hFFFF)
                                               : $urandom_range(0, 24),
                   $urandom_range(0, 3));
            set_ld($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                   ($urandom_range(0, 9) == 0) ? $urandom_range(16'hFFF0, 16'hFFFF)
                                               : $urandom_range(0, 24),
                   $urandom_range(0, 3));
            step();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule